// File: doc/BRIEF.md
# Pixel Clock Strobe Generator

This block runs in the pixel clock domain and derives three enable-style outputs from it. The first is a load strobe at the pixel rate divided by the active multiplex factor (1, 2 or 4), which a pixel front end uses to capture incoming multi-pixel words. The second is a programmable divided clock at the pixel rate over 4, 8, 16 or 32. The third is a video shift clock: an externally supplied shift clock copied to the output, but stopped while blanking is asserted.

One free-running counter feeds both divided outputs, so they stay phase-locked to each other. Mode and divide changes are picked up only when the counter wraps, which prevents runt pulses. The shift-clock gate opens or closes only on the rising edge of the shift clock, so every pulse that reaches the output is complete. All outputs are registered square waves, modelled one pixel clock after their inputs.

Top module: `pix_clk_strobes`

## Requirements
- R1: While reset is low, `load_o`, `prog_o` and `shift_o` are 0 and the counter is 0. After reset the active settings are the 1:1 multiplex mode and the divide by 4, and the shift gate is closed.
- R2: With active multiplex mode code 00 (1:1), `load_o` is 1 after every pixel clock edge.
- R3: With active mode code 01 (2:1), `load_o` has period 2. It is 1 after the edge at which the counter held an even value and 0 otherwise.
- R4: With active mode code 10 (4:1), `load_o` has period 4: two cycles high, then two low. It is 1 after edges at which counter bit 1 was 0. The spare code 11 behaves the same as 10.
- R5: `prog_o` has period N with 50% duty cycle, where divide-select code 00/01/10/11 gives N = 4/8/16/32. It is 1 after edges at which counter bit (code+1) was 0.
- R6: The 5-bit counter starts at 0 after reset and increments on every edge. `mux_mode_i` and `div_sel_i` are sampled only at the edge where the counter holds 31, and they govern the outputs from the next edge on. Changes at any other time have no effect.
- R7: `shift_o` equals `shift_clk_i` from the previous edge while the gate is open, and is 0 while the gate is closed.
- R8: The gate changes only at an edge where `shift_clk_i` is 1 and was 0 at the previous edge; it then takes the inverse of `blank_i`, and that new state already applies to the same edge. Values of `blank_i` at other edges are ignored.
- R9: All outputs are registered. Each one reflects the inputs and state sampled at the preceding pixel clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| mux_mode_i | input | 2 | Multiplex mode: 00 1:1, 01 2:1, 10 and 11 4:1 |
| div_sel_i | input | DIV_SEL_W (2) | Programmable divide: 00 /4, 01 /8, 10 /16, 11 /32 |
| shift_clk_i | input | 1 | External video shift clock, sampled by the pixel clock |
| blank_i | input | 1 | Blanking, active high |
| load_o | output | 1 | Load strobe at pixel rate over M |
| prog_o | output | 1 | Programmable divided clock |
| shift_o | output | 1 | Gated shift clock |

## Verification
If the counter is skewed, both divided outputs shift phase together, and the scoreboard sees this on the first edge where an expected transition is missed, at most half a period into the active divide. If an active setting latches at the wrong time, the result appears right after the wrong edge, because the period changes outside the count of 31. A gate that reacts to blanking outside a shift-clock rising edge shows up as a cut-short or missing pulse within one shift-clock high phase.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [1:0] {
    MUX_1TO1  = 2'b00,
    MUX_2TO1  = 2'b01,
    MUX_4TO1  = 2'b10,
    MUX_4TO1B = 2'b11
  } mux_mode_e;

  localparam int unsigned MUX_W = 2;
endpackage

// File: rtl/pcg_wrap_counter.sv
module pcg_wrap_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = &cnt_q;
endmodule

// File: rtl/pcg_setting_hold.sv
module pcg_setting_hold #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (en_i) hold_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  assign q_o = hold_q;
endmodule

// File: rtl/pcg_strobe_gen.sv
module pcg_strobe_gen
  import pcg_pkg::*;
#(
  parameter int unsigned DIV_SEL_W = 2,
  parameter int unsigned CNT_W     = (1 << DIV_SEL_W) + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [MUX_W-1:0]     act_mux_i,
  input  logic [DIV_SEL_W-1:0] act_div_i,
  output logic                 load_o,
  output logic                 prog_o
);
  localparam int unsigned NTAP = 1 << DIV_SEL_W;

  logic [NTAP-1:0] taps;
  logic            load_d, prog_d;
  logic            load_q, prog_q;

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign taps[g] = ~cnt_i[g+1];
  end

  always_comb begin
    unique case (mux_mode_e'(act_mux_i))
      MUX_1TO1: load_d = 1'b1;
      MUX_2TO1: load_d = ~cnt_i[0];
      default:  load_d = ~cnt_i[1];
    endcase
    prog_d = taps[act_div_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      prog_q <= 1'b0;
    end else begin
      load_q <= load_d;
      prog_q <= prog_d;
    end
  end

  assign load_o = load_q;
  assign prog_o = prog_q;
endmodule

// File: rtl/pcg_shift_gate.sv
module pcg_shift_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_clk_i,
  input  logic blank_i,
  output logic sck_prev_o,
  output logic gate_o,
  output logic shift_o
);
  logic sck_q, gate_q, shift_q;
  logic rise, gate_d, shift_d;

  always_comb begin
    rise    = shift_clk_i & ~sck_q;
    gate_d  = rise ? ~blank_i : gate_q;
    shift_d = shift_clk_i & gate_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      gate_q  <= 1'b0;
      shift_q <= 1'b0;
    end else begin
      sck_q   <= shift_clk_i;
      gate_q  <= gate_d;
      shift_q <= shift_d;
    end
  end

  assign sck_prev_o = sck_q;
  assign gate_o     = gate_q;
  assign shift_o    = shift_q;
endmodule

// File: rtl/pix_clk_strobes.sv
module pix_clk_strobes
  import pcg_pkg::*;
#(
  parameter int unsigned DIV_SEL_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mux_mode_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic                 shift_clk_i,
  input  logic                 blank_i,
  output logic                 load_o,
  output logic                 prog_o,
  output logic                 shift_o
);
  localparam int unsigned CNT_W = (1 << DIV_SEL_W) + 1;

  logic [CNT_W-1:0]     cnt_q;
  logic                 wrap;
  logic [MUX_W-1:0]     act_mux;
  logic [DIV_SEL_W-1:0] act_div;
  logic                 sck_q;
  logic                 gate_q;

  pcg_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  pcg_setting_hold #(.W(MUX_W)) u_mux_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wrap),
    .d_i    (mux_mode_i),
    .q_o    (act_mux)
  );

  pcg_setting_hold #(.W(DIV_SEL_W)) u_div_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wrap),
    .d_i    (div_sel_i),
    .q_o    (act_div)
  );

  pcg_strobe_gen #(.DIV_SEL_W(DIV_SEL_W), .CNT_W(CNT_W)) u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt_q),
    .act_mux_i (act_mux),
    .act_div_i (act_div),
    .load_o    (load_o),
    .prog_o    (prog_o)
  );

  pcg_shift_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_clk_i (shift_clk_i),
    .blank_i     (blank_i),
    .sck_prev_o  (sck_q),
    .gate_o      (gate_q),
    .shift_o     (shift_o)
  );
endmodule

// File: rtl/pcg_checker.sv
module pcg_checker #(
  parameter int unsigned DIV_SEL_W = 2,
  parameter int unsigned CNT_W     = (1 << DIV_SEL_W) + 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 shift_clk_i,
  input logic                 load_o,
  input logic                 prog_o,
  input logic                 shift_o,
  input logic [CNT_W-1:0]     cnt_q,
  input logic [1:0]           act_mux,
  input logic [DIV_SEL_W-1:0] act_div,
  input logic                 sck_q,
  input logic                 gate_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_low: assert (!load_o && !prog_o && !shift_o && cnt_q == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  a_r2_load_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mux == 2'b00 && $past(act_mux) == 2'b00) |=> load_o);

  a_r3_load_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mux == 2'b01 && $past(act_mux) == 2'b01) |=> (load_o != $past(load_o)));

  a_r6_div_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_div) |-> ($past(cnt_q) == {CNT_W{1'b1}}));

  a_r6_mux_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_mux) |-> ($past(cnt_q) == {CNT_W{1'b1}}));

  a_r7_shift_needs_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |-> $past(shift_clk_i));

  a_r8_gate_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_q) |-> ($past(shift_clk_i) && !$past(sck_q)));
endmodule

bind pix_clk_strobes pcg_checker #(.DIV_SEL_W(DIV_SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .shift_clk_i (shift_clk_i),
  .load_o      (load_o),
  .prog_o      (prog_o),
  .shift_o     (shift_o),
  .cnt_q       (cnt_q),
  .act_mux     (act_mux),
  .act_div     (act_div),
  .sck_q       (sck_q),
  .gate_q      (gate_q)
);

// File: tb/pix_clk_strobes_tb_top.sv
module pix_clk_strobes_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mux_mode;
  logic [1:0] div_sel;
  logic       sck;
  logic       blank;
  logic       load_w, prog_w, shift_w;

  always #5 clk = ~clk;

  pix_clk_strobes #(.DIV_SEL_W(2)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mux_mode_i  (mux_mode),
    .div_sel_i   (div_sel),
    .shift_clk_i (sck),
    .blank_i     (blank),
    .load_o      (load_w),
    .prog_o      (prog_w),
    .shift_o     (shift_w)
  );

  typedef struct {
    logic  ld;
    logic  pg;
    logic  sh;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  int total = 0;
  int bad   = 0;

  int m_cnt, m_mode, m_div;
  logic m_sck_prev, m_gate;

  task automatic chk(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s got=%b exp=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_mode = 0; m_div = 0;
    m_sck_prev = 1'b0; m_gate = 1'b0;
  endtask

  // driver: apply inputs, push the outputs expected after the next edge
  task automatic step(string tag, int md, int dv, logic s, logic b);
    exp_t e;
    logic rise, gate_n;
    mux_mode = md[1:0]; div_sel = dv[1:0]; sck = s; blank = b;
    if (m_mode == 0)      e.ld = 1'b1;
    else if (m_mode == 1) e.ld = ((m_cnt & 1) == 0);
    else                  e.ld = (((m_cnt >> 1) & 1) == 0);
    e.pg = (((m_cnt >> (m_div + 1)) & 1) == 0);
    rise   = s && !m_sck_prev;
    gate_n = rise ? !b : m_gate;
    e.sh   = s && gate_n;
    e.tag  = tag;
    q.push_back(e);
    if (m_cnt == 31) begin m_mode = md; m_div = dv; end
    m_cnt = (m_cnt + 1) % 32;
    m_sck_prev = s;
    m_gate = gate_n;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    chk("R1", "load", load_w, 1'b0);
    chk("R1", "prog", prog_w, 1'b0);
    chk("R1", "shift", shift_w, 1'b0);
    @(posedge clk);
    #2;
    rst_n = 1'b1;
    model_reset();
  endtask

  // monitor: compare outputs just after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      mon_e = q.pop_front();
      chk(mon_e.tag, "load",  load_w,  mon_e.ld);
      chk(mon_e.tag, "prog",  prog_w,  mon_e.pg);
      chk(mon_e.tag, "shift", shift_w, mon_e.sh);
    end
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1; mux_mode = 2'b00; div_sel = 2'b00; sck = 1'b0; blank = 1'b0;
    #1;
    do_reset();
    // R2 and R5 (/4) at the settings active after reset; R9 latency
    for (int i = 0; i < 40; i++) step("R2 R5 R9", 0, 0, 1'b0, 1'b0);
    // R6: request 2:1 and /8 mid-count; takes effect only after the wrap
    for (int i = 0; i < 70; i++) step("R3 R5 R6", 1, 1, 1'b0, 1'b0);
    for (int i = 0; i < 70; i++) step("R4 R5 R6", 2, 2, 1'b0, 1'b0);
    // spare mode code and /32
    for (int i = 0; i < 100; i++) step("R4 R5", 3, 3, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) step("R2 R6", 0, 0, 1'b0, 1'b0);
    // R7: shift clock passes, stops during a blanking window
    for (int i = 0; i < 64; i++)
      step("R7 R8", 0, 0, ((i >> 1) & 1) == 1, (i >= 16 && i < 40));
    // R8: blank high away from the rising edge is ignored
    for (int i = 0; i < 32; i++)
      step("R8", 0, 0, ((i >> 1) & 1) == 1, (i % 4) == 3);
    // R8: blank high only at the rising edge closes the gate
    for (int i = 0; i < 32; i++)
      step("R8", 0, 0, ((i >> 1) & 1) == 1, (i % 4) == 2);
    for (int i = 0; i < 16; i++)
      step("R7", 0, 0, ((i >> 1) & 1) == 1, 1'b0);
    // R1: reset in mid-run clears everything, gate closed after
    do_reset();
    for (int i = 0; i < 40; i++)
      step("R1 R2 R7", 1, 2, ((i >> 1) & 1) == 1, 1'b1);
    @(posedge clk);
    #3;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule